// File: doc/BRIEF.md
# UART Transmit Flow Controller

This block sits between a byte producer and a UART transmitter. It decides when the next byte may be handed to the transmitter. A mode input selects between two pacing schemes. In hardware mode a clear-to-send line from the far end gates each new byte. In software mode the far end sends in-band pause and resume characters on the received stream, and this block removes those characters before the receive path stores them.

The block also protects the local receive buffer. In software mode it watches the buffer fill level. When the level reaches a high-water mark, it injects a pause character into the transmit stream. When the level drains to a low-water mark, it injects a resume character. These injected characters go ahead of any queued payload. They are raised early, while buffer space remains, so that bytes already on the wire still fit.

A byte that has been offered to the transmitter is never withdrawn or altered. A dropping clear-to-send line or an incoming pause only stops the next byte.

Top module: `uart_tx_flowctl`

## Requirements
- R1: In hardware mode (`sw_mode`=0), a payload byte is accepted only while the clear-to-send input, after a two-register synchronizer, is high. A rise of `cts_async` before edge k makes `in_ready` able to go high only after edge k+1.
- R2: Once `tx_valid` is high, it stays high with `tx_data` unchanged until a cycle with `tx_ready` high. This holds whatever happens to clear-to-send, pause characters or mode.
- R3: In software mode, a received 0x13 stops new payload acceptance from the next cycle on. A received 0x11 re-enables it from the next cycle on.
- R4: In software mode, received 0x11 and 0x13 never appear on `rx_out_*`. Every other received byte appears on `rx_out_*` one cycle after it arrives.
- R5: In hardware mode, every received byte, 0x11 and 0x13 included, appears on `rx_out_*` one cycle after it arrives.
- R6: In software mode, when `rx_level` >= HI_MARK (default 12) and no pause is outstanding, the block offers 0x13 on the transmitter. It sends it only once until a resume has been sent.
- R7: In software mode, when a pause is outstanding and `rx_level` <= LO_MARK (default 4), the block offers 0x11 once.
- R8: A pending pause or resume character is loaded ahead of a waiting payload byte. The payload byte follows after the character has been accepted.
- R9: After reset, `tx_valid` and `rx_out_valid` are low and the remote side is treated as resumed. In software mode with a low fill level, `in_ready` is high.
- R10: In hardware mode, no pause or resume character is generated whatever the fill level. Payload reaches the transmitter in the order it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_mode | input | 1 | 1 = in-band character pacing, 0 = clear-to-send pacing |
| cts_async | input | 1 | Clear-to-send from far end, asynchronous, active high |
| in_data | input | 8 | Payload byte from producer |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Payload byte taken on this edge when in_valid is high |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | Offer present |
| tx_ready | input | 1 | Transmitter takes the offer on this edge |
| rx_in_data | input | 8 | Byte from the UART receiver |
| rx_in_valid | input | 1 | Received byte strobe |
| rx_out_data | output | 8 | Filtered byte toward the receive buffer |
| rx_out_valid | output | 1 | Filtered byte strobe |
| rx_level | input | LEVEL_W (5) | Receive buffer fill level |

## Verification
Each result has a fixed latency. A filtered received byte, a pause or resume state change, and a newly loaded offer all appear one edge after the causing input. A change on clear-to-send reaches `in_ready` two edges after the driven value. The bench drives inputs on the falling edge and samples the outputs either at the next falling edge or one nanosecond later. For the combinational `in_ready`, the sample point is placed precisely at the cycle in which the synchronizer or pause flag is due to change. The random phase keeps a history of the clear-to-send values that applied at each rising edge. It checks every new offer against the value from two edges earlier.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CHAR_RESUME = 8'h11;
    localparam logic [BYTE_W-1:0] CHAR_PAUSE  = 8'h13;

    typedef enum logic [1:0] {
        SRC_DATA  = 2'd0,
        SRC_XON   = 2'd1,
        SRC_XOFF  = 2'd2
    } src_e;

    typedef struct packed {
        logic              vld;
        src_e              src;
        logic [BYTE_W-1:0] byte_q;
    } offer_t;

    function automatic logic is_flow_char(logic [BYTE_W-1:0] b);
        return (b == CHAR_RESUME) || (b == CHAR_PAUSE);
    endfunction

    function automatic logic [BYTE_W-1:0] char_of(src_e s, logic [BYTE_W-1:0] payload);
        case (s)
            SRC_XON:  return CHAR_RESUME;
            SRC_XOFF: return CHAR_PAUSE;
            default:  return payload;
        endcase
    endfunction

endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cts_async,
    output logic cts_sync
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= cts_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign cts_sync = chain[STAGES-1];

endmodule

// File: rtl/fc_rx_filter.sv
module fc_rx_filter import uart_fc_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_mode,
    input  logic [BYTE_W-1:0] rx_in_data,
    input  logic              rx_in_valid,
    output logic [BYTE_W-1:0] rx_out_data,
    output logic              rx_out_valid,
    output logic              remote_paused
);
    logic strip_now;

    assign strip_now = rx_in_valid && sw_mode && is_flow_char(rx_in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_out_valid  <= 1'b0;
            rx_out_data   <= '0;
            remote_paused <= 1'b0;
        end else begin
            rx_out_valid <= 1'b0;
            if (strip_now) begin
                remote_paused <= (rx_in_data == CHAR_PAUSE);
            end else if (rx_in_valid) begin
                rx_out_valid <= 1'b1;
                rx_out_data  <= rx_in_data;
            end
        end
    end

    // R4: pacing characters are removed in software mode
    p_strip_r4: assert property (@(posedge clk) disable iff (rst)
        rx_in_valid && sw_mode && is_flow_char(rx_in_data) |=> !rx_out_valid);

    // R5: everything else passes with one cycle of latency
    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        rx_in_valid && !(sw_mode && is_flow_char(rx_in_data))
        |=> rx_out_valid && rx_out_data == $past(rx_in_data));

    p_pause_r3: assert property (@(posedge clk) disable iff (rst)
        rx_in_valid && sw_mode && rx_in_data == CHAR_PAUSE |=> remote_paused);

    p_resume_r3: assert property (@(posedge clk) disable iff (rst)
        rx_in_valid && sw_mode && rx_in_data == CHAR_RESUME |=> !remote_paused);

    p_pause_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_in_valid |=> $stable(remote_paused));

endmodule

// File: rtl/fc_level_watch.sv
module fc_level_watch #(
    parameter int LEVEL_W = 5,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_mode,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic               take_xoff,
    input  logic               take_xon,
    output logic               need_xoff,
    output logic               need_xon
);
    localparam logic [LEVEL_W-1:0] HI_L = LEVEL_W'(HI_MARK);
    localparam logic [LEVEL_W-1:0] LO_L = LEVEL_W'(LO_MARK);

    logic throttled;

    assign need_xoff = sw_mode && !throttled && (rx_level >= HI_L);
    assign need_xon  = sw_mode &&  throttled && (rx_level <= LO_L);

    always_ff @(posedge clk) begin
        if (rst)            throttled <= 1'b0;
        else if (take_xoff) throttled <= 1'b1;
        else if (take_xon)  throttled <= 1'b0;
    end

    // R6: once a pause has been loaded no second pause is requested
    p_single_pause_r6: assert property (@(posedge clk) disable iff (rst)
        take_xoff |=> !need_xoff);

    // R7: a resume is only ever taken while a pause is outstanding
    p_resume_after_pause_r7: assert property (@(posedge clk) disable iff (rst)
        take_xon |-> throttled);

endmodule

// File: rtl/fc_tx_arbiter.sv
module fc_tx_arbiter import uart_fc_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_mode,
    input  logic              cts_ok,
    input  logic              remote_paused,
    input  logic              need_xoff,
    input  logic              need_xon,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              take_xoff,
    output logic              take_xon
);
    offer_t offer_q;
    logic   slot_free;
    logic   gate_open;

    assign slot_free = !offer_q.vld;
    assign gate_open = sw_mode ? !remote_paused : cts_ok;
    assign take_xoff = slot_free && need_xoff;
    assign take_xon  = slot_free && !need_xoff && need_xon;
    assign in_ready  = slot_free && !need_xoff && !need_xon && gate_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            offer_q <= '0;
        end else if (offer_q.vld) begin
            if (tx_ready) offer_q.vld <= 1'b0;
        end else if (take_xoff) begin
            offer_q <= '{vld: 1'b1, src: SRC_XOFF, byte_q: char_of(SRC_XOFF, in_data)};
        end else if (take_xon) begin
            offer_q <= '{vld: 1'b1, src: SRC_XON, byte_q: char_of(SRC_XON, in_data)};
        end else if (in_valid && in_ready) begin
            offer_q <= '{vld: 1'b1, src: SRC_DATA, byte_q: in_data};
        end
    end

    assign tx_valid = offer_q.vld;
    assign tx_data  = offer_q.byte_q;

    // R2: an offer is never withdrawn or altered before acceptance
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R1: hardware-mode payload loads only on a synchronized clear-to-send
    p_cts_gate_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) && offer_q.src == SRC_DATA && !$past(sw_mode) |-> $past(cts_ok));

    // R3: software-mode payload loads only while the far end is resumed
    p_remote_pause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) && offer_q.src == SRC_DATA && $past(sw_mode) |-> !$past(remote_paused));

    // R8: a pending pause request wins the free slot
    p_ctrl_first_r8: assert property (@(posedge clk) disable iff (rst)
        !tx_valid && need_xoff |=> tx_valid && tx_data == CHAR_PAUSE);

    // R10: hardware mode never injects pacing characters
    p_hw_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) && !$past(sw_mode) |-> offer_q.src == SRC_DATA);

endmodule

// File: rtl/uart_tx_flowctl.sv
module uart_tx_flowctl import uart_fc_pkg::*; #(
    parameter int LEVEL_W   = 5,
    parameter int HI_MARK   = 12,
    parameter int LO_MARK   = 4,
    parameter int CTS_FLOPS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_mode,
    input  logic               cts_async,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    input  logic [7:0]         rx_in_data,
    input  logic               rx_in_valid,
    output logic [7:0]         rx_out_data,
    output logic               rx_out_valid,
    input  logic [LEVEL_W-1:0] rx_level
);
    logic cts_ok;
    logic remote_paused;
    logic need_xoff, need_xon;
    logic take_xoff, take_xon;

    fc_cts_sync #(.STAGES(CTS_FLOPS)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cts_async (cts_async),
        .cts_sync  (cts_ok)
    );

    fc_rx_filter u_filter (
        .clk           (clk),
        .rst           (rst),
        .sw_mode       (sw_mode),
        .rx_in_data    (rx_in_data),
        .rx_in_valid   (rx_in_valid),
        .rx_out_data   (rx_out_data),
        .rx_out_valid  (rx_out_valid),
        .remote_paused (remote_paused)
    );

    fc_level_watch #(
        .LEVEL_W (LEVEL_W),
        .HI_MARK (HI_MARK),
        .LO_MARK (LO_MARK)
    ) u_watch (
        .clk       (clk),
        .rst       (rst),
        .sw_mode   (sw_mode),
        .rx_level  (rx_level),
        .take_xoff (take_xoff),
        .take_xon  (take_xon),
        .need_xoff (need_xoff),
        .need_xon  (need_xon)
    );

    fc_tx_arbiter u_arb (
        .clk           (clk),
        .rst           (rst),
        .sw_mode       (sw_mode),
        .cts_ok        (cts_ok),
        .remote_paused (remote_paused),
        .need_xoff     (need_xoff),
        .need_xon      (need_xon),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .take_xoff     (take_xoff),
        .take_xon      (take_xon)
    );

    // R9: no offer and no received strobe in the cycle after reset
    p_reset_idle_r9: assert property (@(posedge clk)
        $past(rst) |-> !tx_valid && !rx_out_valid);

endmodule

// File: tb/uart_tx_flowctl_tb_top.sv
module uart_tx_flowctl_tb_top;

    localparam int HI = 12;
    localparam int LO = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_mode = 1'b1;
    logic       cts_dir = 1'b0;
    logic       cts_rnd = 1'b1;
    logic       rand_on = 1'b0;
    logic       cts_async;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       ready_dir = 1'b0;
    logic       ready_rnd = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_in_data = '0;
    logic       rx_in_valid = 1'b0;
    logic [7:0] rx_out_data;
    logic       rx_out_valid;
    logic [4:0] rx_level = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] sent_q[$];
    logic [7:0] cap_q[$];

    assign cts_async = rand_on ? cts_rnd : cts_dir;
    assign tx_ready  = rand_on ? ready_rnd : ready_dir;

    always #2 clk = ~clk;

    uart_tx_flowctl #(.LEVEL_W(5), .HI_MARK(HI), .LO_MARK(LO)) dut_i (
        .clk(clk), .rst(rst), .sw_mode(sw_mode), .cts_async(cts_async),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid),
        .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid),
        .rx_level(rx_level)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic logic [7:0] safe_byte(input logic [7:0] b);
        return (b == 8'h11 || b == 8'h13) ? 8'h41 : b;
    endfunction

    // offers a byte at a falling edge, holds it until the design takes it
    task automatic push(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        for (int t = 0; t < 4000; t++) begin
            #1;
            if (in_ready) begin
                @(negedge clk);
                sent_q.push_back(b);
                in_valid = 1'b0;
                return;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(0, "R1 push stalled", 0, 1);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx_in_data  = b;
        rx_in_valid = 1'b1;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic drain_one();
        ready_dir = 1'b1;
        @(negedge clk);
        ready_dir = 1'b0;
    endtask

    // random-phase transmitter model and per-edge checks
    logic h0 = 1'b0, h1 = 1'b0, h2 = 1'b0;
    logic prev_tv = 1'b0, prev_hs = 1'b0;
    logic [7:0] prev_data = '0;
    int warm = 0;
    always @(negedge clk) begin
        if (rand_on) begin
            h2 = h1; h1 = h0; h0 = cts_async;
            if (warm >= 4) begin
                if (tx_valid && !prev_tv)
                    check(h2 == 1'b1, "R1 load needs cts two edges back", h2, 1);
                if (prev_tv && !prev_hs)
                    check(tx_valid && tx_data == prev_data, "R2 offer held", tx_data, prev_data);
            end
            warm++;
            if ($urandom % 8 == 0) cts_rnd = ~cts_rnd;
            ready_rnd = ($urandom % 3) != 0;
            prev_hs = tx_valid && ready_rnd;
            if (prev_hs) cap_q.push_back(tx_data);
            prev_tv = tx_valid;
            prev_data = tx_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check(!tx_valid, "R9 tx_valid in reset", tx_valid, 0);
        check(!rx_out_valid, "R9 rx_out_valid in reset", rx_out_valid, 0);
        rst = 1'b0;
        #1;
        check(in_ready, "R9 resumed after reset", in_ready, 1);
        @(negedge clk);

        // R4: ordinary byte passes in software mode
        rx_byte(8'h41);
        check(rx_out_valid && rx_out_data == 8'h41, "R4 plain byte passes", rx_out_data, 8'h41);

        // R3/R4: pause character stripped and stops payload
        rx_byte(8'h13);
        check(!rx_out_valid, "R4 pause stripped", rx_out_valid, 0);
        in_data = 8'h55; in_valid = 1'b1;
        #1;
        check(!in_ready, "R3 paused blocks payload", in_ready, 0);
        repeat (3) @(negedge clk);
        #1;
        check(!tx_valid && !in_ready, "R3 still paused", tx_valid, 0);
        @(negedge clk);
        rx_byte(8'h11);
        check(!rx_out_valid, "R4 resume stripped", rx_out_valid, 0);
        #1;
        check(in_ready, "R3 resume reopens", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(tx_valid && tx_data == 8'h55, "R3 payload after resume", tx_data, 8'h55);

        // R2: offer held across a pause while not accepted
        rx_byte(8'h13);
        for (int i = 0; i < 3; i++) begin
            check(tx_valid && tx_data == 8'h55, "R2 held during pause", tx_data, 8'h55);
            @(negedge clk);
        end
        rx_byte(8'h11);
        drain_one();
        check(!tx_valid, "R2 released after accept", tx_valid, 0);

        // R6: high-water pause, sent once
        rx_level = 5'(HI);
        @(negedge clk);
        check(tx_valid && tx_data == 8'h13, "R6 pause at high water", tx_data, 8'h13);
        drain_one();
        for (int i = 0; i < 4; i++) begin
            check(!tx_valid, "R6 single pause", tx_valid, 0);
            @(negedge clk);
        end

        // R7/R8: resume at low water goes ahead of waiting payload
        in_data = 8'h66; in_valid = 1'b1; rx_level = 5'(LO);
        @(negedge clk);
        check(tx_valid && tx_data == 8'h11, "R8 R7 resume before payload", tx_data, 8'h11);
        drain_one();
        @(negedge clk);
        in_valid = 1'b0;
        check(tx_valid && tx_data == 8'h66, "R8 payload follows", tx_data, 8'h66);
        drain_one();

        // R5: hardware mode passes pacing characters
        sw_mode = 1'b0;
        rx_byte(8'h13);
        check(rx_out_valid && rx_out_data == 8'h13, "R5 unfiltered in hw mode", rx_out_data, 8'h13);

        // R1: synchronizer latency
        in_data = 8'h77; in_valid = 1'b1;
        #1;
        check(!in_ready, "R1 blocked with cts low", in_ready, 0);
        @(negedge clk);
        cts_dir = 1'b1;
        @(negedge clk);
        #1;
        check(!in_ready, "R1 one edge not enough", in_ready, 0);
        @(negedge clk);
        #1;
        check(in_ready, "R1 open after two edges", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(tx_valid && tx_data == 8'h77, "R1 payload loaded", tx_data, 8'h77);
        cts_dir = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tx_valid && tx_data == 8'h77, "R2 held after cts drop", tx_data, 8'h77);
        end
        drain_one();
        check(!tx_valid, "R2 accepted in hw mode", tx_valid, 0);

        // R10: no generated characters in hw mode
        rx_level = 5'd20;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!tx_valid, "R10 quiet at high level", tx_valid, 0);
        end

        // random hardware-mode traffic
        sent_q.delete();
        rand_on = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 120; n++) begin
            push(safe_byte(8'($urandom)));
            repeat ($urandom % 3) @(negedge clk);
        end
        for (int t = 0; t < 4000 && cap_q.size() < sent_q.size(); t++) @(negedge clk);
        check(cap_q.size() == sent_q.size(), "R10 byte count", cap_q.size(), sent_q.size());
        for (int i = 0; i < sent_q.size() && i < cap_q.size(); i++)
            check(cap_q[i] == sent_q[i], "R10 order and content", cap_q[i], sent_q[i]);
        rand_on = 1'b0;
        @(negedge clk);

        report();
        $finish;
    end

endmodule